// File: doc/BRIEF.md
# Fair Handoff Hardware Lock

This block arbitrates one mutual-exclusion lock among `N` requesters. A requester raises its acquire line for a cycle to ask for the lock. If the lock is free, the unit takes it for that requester in a single indivisible step: it reads the held state and sets it at the same clock edge. The new owner receives a one-cycle grant pulse, and the owner outputs name it for as long as it holds the lock.

Requests that arrive while the lock is held are kept as pending flags, one flag per requester. When the owner releases, the unit does not free the lock for a new race. It scans the pending flags in circular order, beginning just after the releaser, and passes ownership in the same cycle to the first requester it finds. Because of this, no waiting requester can be passed over by more than `N-1` others. The lock goes free only when nobody is pending. A release from any requester other than the owner has no effect on the lock and sets a sticky error flag.

Top module: `bw_lock_unit`

## Requirements
- R1: After reset, `ownerValid`, `grant` and `relError` are all 0.
- R2: When the lock is free and one requester raises `acqReq`, then after the next clock edge `grant` has only that requester's bit set, `ownerId` gives its index and `ownerValid` is 1.
- R3: When several requesters ask for a free lock in the same cycle, the winner is the first of them in circular order after the most recent owner; after reset, index 0 comes first. The others stay pending.
- R4: While the lock is held, an acquire from another requester gives no grant and leaves the owner unchanged. The request stays pending until that requester is served.
- R5: When the owner releases and requests are pending, the lock goes at the next edge to the first pending requester found from (owner+1) mod N onward, wrapping around. That requester gets a grant pulse, and `ownerValid` stays 1 throughout.
- R6: When the owner releases and nothing is pending, `ownerValid` is 0 after the next edge and no grant is issued.
- R7: An acquire raised in the same cycle as the owner's release is included in that release's handoff search.
- R8: A release from a requester that is not the owner, including any release while the lock is free, leaves the owner, `ownerValid` and the pending flags unchanged. It sets `relError`, which stays 1 until reset.
- R9: `grant` has at most one bit set, and each grant lasts exactly one cycle.
- R10: A pending requester is granted after at most N-1 grants to other requesters.
- R11: An acquire from the current owner is not recorded. If the owner releases with no one else pending, the lock goes free and is not granted to it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| acqReq | input | N | Acquire request, one bit per requester |
| relReq | input | N | Release request, one bit per requester |
| grant | output | N | One-cycle ownership pulse to the new owner |
| ownerId | output | clog2(N) | Index of the current owner, meaningful while ownerValid is 1 |
| ownerValid | output | 1 | The lock is held |
| relError | output | 1 | Sticky flag: a release came from a requester that does not own the lock |

## Verification
Two functions can fall in the same cycle: the owner's release with its handoff search, and a fresh acquire from another requester. The bench raises a new acquire in the very cycle the owner releases. It checks that the newcomer wins when it comes first in circular order ahead of an older pending request. In the same way, the owner's own acquire coinciding with its release must not bring the lock back to it. A stray release is sent while a real handoff is pending, and the bench checks that the handoff is unchanged and that only the error flag moves.

// File: rtl/bw_lock_pkg.sv
package bw_lock_pkg;

  // Strobes from the control to the datapath for one cycle
  typedef struct packed {
    logic grantNext;  // give the lock to the searched candidate
    logic freeLock;   // drop the lock, nobody pending
    logic flagErr;    // record a stray release
  } lockStrobe_t;

endpackage

// File: rtl/bw_lock_ctrl.sv
module bw_lock_ctrl
  import bw_lock_pkg::*;
(
  input  logic        lockHeld,
  input  logic        relByOwner,
  input  logic        relStray,
  input  logic        found,
  output lockStrobe_t strobe
);

  always_comb begin
    strobe = '0;
    if (lockHeld) begin
      // handoff path: only the owner's release opens a search result
      strobe.grantNext = relByOwner & found;
      strobe.freeLock  = relByOwner & ~found;
    end else begin
      // test-and-set path: free lock goes to the first pending requester
      strobe.grantNext = found;
    end
    strobe.flagErr = relStray;
  end

endmodule

// File: rtl/bw_lock_dpath.sv
module bw_lock_dpath
  import bw_lock_pkg::*;
#(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   acqReq,
  input  logic [N-1:0]   relReq,
  input  lockStrobe_t    strobe,
  output logic           lockHeld,
  output logic           relByOwner,
  output logic           relStray,
  output logic           found,
  output logic [N-1:0]   grant,
  output logic [IDW-1:0] ownerId,
  output logic           relError
);

  localparam logic [IDW-1:0] LAST_ID = IDW'(N - 1);
  localparam logic [IDW:0]   NUM_REQ = (IDW + 1)'(N);

  logic [N-1:0]   waitQ;
  logic [N-1:0]   grantQ;
  logic [IDW-1:0] ownerQ;
  logic           lockQ;
  logic           errQ;

  logic [N-1:0]   ownerMask;
  logic [N-1:0]   pending;
  logic [N-1:0]   nextMask;
  logic [IDW-1:0] startId;
  logic [IDW-1:0] nextId;
  logic [IDW:0]   pos;

  assign ownerMask  = lockQ ? (N'(1) << ownerQ) : '0;
  assign pending    = waitQ | (acqReq & ~ownerMask);
  assign relByOwner = lockQ & relReq[ownerQ];
  assign relStray   = |(relReq & ~ownerMask);
  assign startId    = (ownerQ == LAST_ID) ? '0 : ownerQ + 1'b1;
  assign nextMask   = N'(1) << nextId;

  // circular scan from the slot after the last owner
  always_comb begin
    found  = 1'b0;
    nextId = '0;
    pos    = '0;
    for (int k = 0; k < N; k++) begin
      pos = {1'b0, startId} + (IDW + 1)'(k);
      if (pos >= NUM_REQ) pos = pos - NUM_REQ;
      if (!found && pending[pos[IDW-1:0]]) begin
        found  = 1'b1;
        nextId = pos[IDW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitQ  <= '0;
      grantQ <= '0;
      ownerQ <= LAST_ID;
      lockQ  <= 1'b0;
      errQ   <= 1'b0;
    end else begin
      waitQ  <= pending & ~(strobe.grantNext ? nextMask : '0);
      grantQ <= strobe.grantNext ? nextMask : '0;
      if (strobe.grantNext) begin
        ownerQ <= nextId;
        lockQ  <= 1'b1;
      end else if (strobe.freeLock) begin
        lockQ  <= 1'b0;
      end
      if (strobe.flagErr) errQ <= 1'b1;
    end
  end

  assign lockHeld = lockQ;
  assign grant    = grantQ;
  assign ownerId  = ownerQ;
  assign relError = errQ;

  // a grant always names the current holder
  assert_grant_owner_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|grantQ) |-> (lockQ && grantQ[ownerQ]));

  // a held lock moves only on the owner's release
  assert_hold_owner_R4: assert property (@(posedge clk) disable iff (!rstN)
    (lockQ && !relByOwner) |=> (lockQ && $stable(ownerQ)));

  // handoff keeps the lock held and moves it to someone else
  assert_handoff_R5: assert property (@(posedge clk) disable iff (!rstN)
    (relByOwner && found) |=> (lockQ && (ownerQ != $past(ownerQ)) && (|grantQ)));

  // release with no one pending frees the lock silently
  assert_free_lock_R6: assert property (@(posedge clk) disable iff (!rstN)
    (relByOwner && !found) |=> (!lockQ && (grantQ == '0)));

  // error flag never clears without reset
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);

  // grants are single-bit, single-cycle pulses
  assert_grant_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantQ));
  assert_grant_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|grantQ) |=> ((grantQ & $past(grantQ)) == '0));

endmodule

// File: rtl/bw_lock_unit.sv
module bw_lock_unit
  import bw_lock_pkg::*;
#(
  parameter  int N   = 4,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [N-1:0]   acqReq,
  input  logic [N-1:0]   relReq,
  output logic [N-1:0]   grant,
  output logic [IDW-1:0] ownerId,
  output logic           ownerValid,
  output logic           relError
);

  lockStrobe_t strobe;
  logic        lockHeld;
  logic        relByOwner;
  logic        relStray;
  logic        found;

  bw_lock_ctrl ctrl_i (
    .lockHeld   (lockHeld),
    .relByOwner (relByOwner),
    .relStray   (relStray),
    .found      (found),
    .strobe     (strobe)
  );

  bw_lock_dpath #(.N(N), .IDW(IDW)) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .acqReq     (acqReq),
    .relReq     (relReq),
    .strobe     (strobe),
    .lockHeld   (lockHeld),
    .relByOwner (relByOwner),
    .relStray   (relStray),
    .found      (found),
    .grant      (grant),
    .ownerId    (ownerId),
    .relError   (relError)
  );

  assign ownerValid = lockHeld;

endmodule

// File: tb/bw_lock_unit_tb_top.sv
`timescale 1ns/100ps
module bw_lock_unit_tb_top;

  localparam int N  = 4;
  localparam int NV = 16;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] acqReq = '0;
  logic [3:0] relReq = '0;
  logic [3:0] grant;
  logic [1:0] ownerId;
  logic       ownerValid;
  logic       relError;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  bw_lock_unit #(.N(N)) dut_i (
    .clk(clk), .rstN(rstN), .acqReq(acqReq), .relReq(relReq),
    .grant(grant), .ownerId(ownerId), .ownerValid(ownerValid), .relError(relError)
  );

  // {acq, rel, expGrant, expOwner, expValid, expErr}
  localparam logic [15:0] VEC [NV] = '{
    {4'b0001, 4'b0000, 4'b0001, 2'd0, 1'b1, 1'b0},  // R2 single take
    {4'b0110, 4'b0000, 4'b0000, 2'd0, 1'b1, 1'b0},  // R4 queued while held
    {4'b0000, 4'b0001, 4'b0010, 2'd1, 1'b1, 1'b0},  // R5 handoff to 1
    {4'b0001, 4'b0000, 4'b0000, 2'd1, 1'b1, 1'b0},  // R4 queue 0
    {4'b0000, 4'b0010, 4'b0100, 2'd2, 1'b1, 1'b0},  // R5 handoff to 2
    {4'b1000, 4'b0100, 4'b1000, 2'd3, 1'b1, 1'b0},  // R7 newcomer 3 beats 0
    {4'b0000, 4'b1000, 4'b0001, 2'd0, 1'b1, 1'b0},  // R5 wrap to 0
    {4'b0001, 4'b0001, 4'b0000, 2'd0, 1'b0, 1'b0},  // R11 owner acquire ignored
    {4'b0000, 4'b0000, 4'b0000, 2'd0, 1'b0, 1'b0},  // R11 stays free
    {4'b1111, 4'b0000, 4'b0010, 2'd1, 1'b1, 1'b0},  // R3 first after last owner 0
    {4'b0000, 4'b0100, 4'b0000, 2'd1, 1'b1, 1'b1},  // R8 stray release
    {4'b0000, 4'b0010, 4'b0100, 2'd2, 1'b1, 1'b1},  // R5 handoff to 2
    {4'b0000, 4'b0100, 4'b1000, 2'd3, 1'b1, 1'b1},  // R10 then 3
    {4'b0000, 4'b1000, 4'b0001, 2'd0, 1'b1, 1'b1},  // R10 0 after three others
    {4'b0000, 4'b0001, 4'b0000, 2'd0, 1'b0, 1'b1},  // R6 free
    {4'b0000, 4'b0001, 4'b0000, 2'd0, 1'b0, 1'b1}   // R8 release while free
  };

  function automatic string tagOf(int i);
    case (i)
      0:       return "R2";
      1, 3:    return "R4";
      5:       return "R7";
      7, 8:    return "R11";
      9:       return "R3";
      10, 15:  return "R8";
      12, 13:  return "R10";
      14:      return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(string tag, logic [3:0] eg, logic [1:0] eo, logic ev, logic ee);
    checks++;
    if (grant !== eg || ownerValid !== ev || relError !== ee || (ev && ownerId !== eo)) begin
      fails++;
      $display("FAIL %s: grant=%b owner=%0d valid=%b err=%b, expected grant=%b owner=%0d valid=%b err=%b",
               tag, grant, ownerId, ownerValid, relError, eg, eo, ev, ee);
    end
  endtask

  task automatic step(logic [3:0] acq, logic [3:0] rel);
    acqReq = acq;
    relReq = rel;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 4'b0000, 2'd0, 1'b0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][15:12], VEC[i][11:8]);
      chk(tagOf(i), VEC[i][7:4], VEC[i][3:2], VEC[i][1], VEC[i][0]);
    end
    step(4'b0000, 4'b0000);

    // mid-run reset clears the sticky error (R1, R8)
    rstN = 1'b0;
    #1;
    chk("R1", 4'b0000, 2'd0, 1'b0, 1'b0);
    @(posedge clk);
    #1;
    rstN = 1'b1;

    step(4'b0010, 4'b0000);
    chk("R2", 4'b0010, 2'd1, 1'b1, 1'b0);
    step(4'b0000, 4'b0000);
    chk("R9", 4'b0000, 2'd1, 1'b1, 1'b0);
    step(4'b0000, 4'b0010);
    chk("R6", 4'b0000, 2'd1, 1'b0, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=still running, expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule